// File: doc/BRIEF.md
# Power-Mode Sequencer

The block decides which of four operating modes a small system-on-chip is in and turns that mode into enable lines. The modes, from highest to lowest power, are full run, reduced run, sleep and deep sleep. Software moves the chip out of full run by writing a mode register. Hardware brings it back through three paths: a masked interrupt wakes it from reduced run, a wakeup source wakes it from either sleep mode, and a reset event works from any mode. Each mode accepts its own fixed set of wakeup and reset sources. Any other source is ignored in that mode.

In the two run modes the subsystem enables and the regulator enables come from a template register. Each run mode has its own template. In the two sleep modes every subsystem enable is forced off, whatever the templates hold. The main clock is off, the retention output is asserted and only the low-power regulator stays on. Leaving a sleep mode starts a wait of a parameterised number of cycles, one count for each sleep mode. During this wait the clocks and regulators restart, but the block does not yet report ready. A one-cycle pulse names the source that caused each wakeup.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After the reset input is released, the mode output is 0 (full run), ready is 1, the subsystem enables are all ones, the regulator enables are all ones and the wakeup pulse is 0.
- R2: Mode codes are 0 for full run, 1 for reduced run, 2 for sleep and 3 for deep sleep. A write to address 0 requests the mode in data bits [1:0], and mode_o shows the new mode one cycle after the write. The request is ignored in sleep, in deep sleep, during a wakeup wait, or when the requested mode equals the current mode.
- R3: The full-run template is at address 1 and the reduced-run template is at address 2. In each template, bits [NSUB-1:0] are the subsystem enables and bits [NSUB+NREG-1:NSUB] are the regulator enables. Each run mode drives sub_en_o and reg_en_o from its own template.
- R4: In sleep and in deep sleep, sub_en_o is 0, retain_o is 1 and reg_lp_en_o is 1. Outside a wakeup wait, clk_en_o is 0 and reg_en_o is 0 in these modes. reg_lp_en_o is 1 in every mode.
- R5: In sleep, lsclk_en_o and i2c_run_o are 1. In deep sleep, both are 0. In the run modes, retain_o is 0.
- R6: The interrupt enable mask is at address 3, data bits [NIRQ-1:0], and is all ones by default. In reduced run, an interrupt whose enable bit is set changes the mode to full run one cycle later and reports cause 6. An interrupt whose enable bit is clear has no effect.
- R7: The wakeup source bits are: bit 0 comparator, bit 1 pin interrupt controller, bit 2 I2C, bit 3 RTC, bit 4 periodic timer and bit 5 low-voltage detector. Any of these sources wakes the block from sleep. ready_o stays 0 for SLP_LAT-1 cycles after the cycle that shows the wakeup pulse, and then rises together with mode 0. During this wait clk_en_o is 1 and sub_en_o is 0.
- R8: In deep sleep only wakeup bit 1 is accepted, and ready rises after HIB_LAT cycles. The other wakeup bits leave the mode at 3 with ready at 0.
- R9: On each accepted wakeup, wake_vld_o is 1 for exactly one cycle. At the same time wake_cause_o gives the index of the lowest accepted wakeup bit that is set.
- R10: The reset source bits are: bit 0 external reset, bit 1 low-voltage detector and bit 2 watchdog. Full run, reduced run and sleep accept all three, and deep sleep accepts only bit 0. An accepted reset source sets mode 0 and ready on the next cycle, restores every template to its default value and cancels any wakeup wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 mode, 1 full-run template, 2 reduced-run template, 3 interrupt mask |
| wr_data_i | input | DW | Write data |
| irq_i | input | NIRQ | Interrupt lines |
| wake_src_i | input | 6 | Wakeup sources |
| rst_src_i | input | 3 | Reset sources |
| mode_o | output | 2 | Current mode code |
| ready_o | output | 1 | Run mode reached, wakeup wait finished |
| sub_en_o | output | NSUB | Subsystem enables |
| reg_en_o | output | NREG | Programmable regulator enables |
| reg_lp_en_o | output | 1 | Low-power regulator enable |
| clk_en_o | output | 1 | Main clock enable |
| lsclk_en_o | output | 1 | Low-speed oscillator enable |
| i2c_run_o | output | 1 | I2C logic keep-alive |
| retain_o | output | 1 | Register and SRAM retention |
| wake_vld_o | output | 1 | One-cycle wakeup report |
| wake_cause_o | output | 3 | Index of the wakeup source, 6 for an interrupt |

## Verification
Some properties are checked on every cycle: the subsystem enables are off and retention is on whenever a sleep mode is shown, ready is low in sleep and deep sleep, and the wakeup pulse never lasts two cycles. Two transition rules are also checked every cycle: sleep can only move to full run, and an external reset always lands in full run. A deep-sleep wakeup must name the pin source. The bench scenarios must show the rest: the exact cycle count of each wakeup wait, the cause index, the effect of template values on the outputs, the interrupt mask, ignored requests and the per-mode reset masks.

// File: rtl/pmc_pkg.sv
package pmc_pkg;

    typedef enum logic [1:0] {
        MODE_ACT = 2'd0,
        MODE_ALT = 2'd1,
        MODE_SLP = 2'd2,
        MODE_HIB = 2'd3
    } pmode_e;

    localparam int NWAKE   = 6;
    localparam int NRST    = 3;
    localparam int CAUSE_W = 3;
    localparam logic [CAUSE_W-1:0] CAUSE_IRQ = 3'd6;

    localparam logic [1:0] A_MODE = 2'd0;
    localparam logic [1:0] A_TACT = 2'd1;
    localparam logic [1:0] A_TALT = 2'd2;
    localparam logic [1:0] A_IRQ  = 2'd3;

    // wakeup sources each mode accepts (bit 1 = pin interrupt controller)
    function automatic logic [NWAKE-1:0] wake_mask(pmode_e m);
        case (m)
            MODE_SLP: return 6'b111111;
            MODE_HIB: return 6'b000010;
            default:  return '0;
        endcase
    endfunction

    // reset sources each mode accepts (bit 0 = external reset)
    function automatic logic [NRST-1:0] rst_mask(pmode_e m);
        if (m == MODE_HIB) return 3'b001;
        return 3'b111;
    endfunction

    function automatic logic is_low(pmode_e m);
        return (m == MODE_SLP) || (m == MODE_HIB);
    endfunction

endpackage

// File: rtl/pmc_src_sel.sv
module pmc_src_sel #(
    parameter int N  = 6,
    parameter int IW = 3
) (
    input  logic [N-1:0]  req_i,
    input  logic [N-1:0]  mask_i,
    output logic          hit_o,
    output logic [IW-1:0] idx_o
);
    logic [N-1:0] acc;

    for (genvar i = 0; i < N; i++) begin : g_gate
        assign acc[i] = req_i[i] & mask_i[i];
    end

    assign hit_o = |acc;

    // lowest accepted index wins
    always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (acc[i]) idx_o = IW'(i);
        end
    end
endmodule

// File: rtl/pmc_latency.sv
module pmc_latency #(
    parameter int CW = 14
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          clr_i,
    input  logic          load_i,
    input  logic [CW-1:0] val_i,
    output logic          busy_o,
    output logic          done_o
);
    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } lat_t;

    lat_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (clr_i) begin
            s_d.busy = 1'b0;
            s_d.cnt  = '0;
        end else if (load_i) begin
            s_d.busy = 1'b1;
            s_d.cnt  = val_i - CW'(1);
        end else if (s_q.busy) begin
            if (s_q.cnt == '0) s_d.busy = 1'b0;
            else               s_d.cnt  = s_q.cnt - CW'(1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= '0;
        else         s_q <= s_d;
    end

    assign busy_o = s_q.busy;
    assign done_o = s_q.busy && (s_q.cnt == '0);
endmodule

// File: rtl/pmc_out_dec.sv
module pmc_out_dec
    import pmc_pkg::*;
#(
    parameter int NSUB = 8,
    parameter int NREG = 2,
    localparam int TW  = NSUB + NREG
) (
    input  pmode_e            mode_i,
    input  logic              waking_i,
    input  logic [TW-1:0]     tpl_act_i,
    input  logic [TW-1:0]     tpl_alt_i,
    output logic [NSUB-1:0]   sub_en_o,
    output logic [NREG-1:0]   reg_en_o,
    output logic              reg_lp_en_o,
    output logic              clk_en_o,
    output logic              lsclk_en_o,
    output logic              i2c_run_o,
    output logic              retain_o
);
    always_comb begin
        reg_lp_en_o = 1'b1;
        case (mode_i)
            MODE_ACT, MODE_ALT: begin
                sub_en_o   = (mode_i == MODE_ACT) ? tpl_act_i[NSUB-1:0] : tpl_alt_i[NSUB-1:0];
                reg_en_o   = (mode_i == MODE_ACT) ? tpl_act_i[TW-1:NSUB] : tpl_alt_i[TW-1:NSUB];
                clk_en_o   = 1'b1;
                lsclk_en_o = 1'b1;
                i2c_run_o  = 1'b1;
                retain_o   = 1'b0;
            end
            default: begin
                sub_en_o   = '0;
                reg_en_o   = waking_i ? tpl_act_i[TW-1:NSUB] : '0;
                clk_en_o   = waking_i;
                lsclk_en_o = (mode_i == MODE_SLP);
                i2c_run_o  = (mode_i == MODE_SLP);
                retain_o   = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
    import pmc_pkg::*;
#(
    parameter int NSUB    = 8,
    parameter int NREG    = 2,
    parameter int NIRQ    = 8,
    parameter int DW      = 16,
    parameter int SLP_LAT = 1400,
    parameter int HIB_LAT = 9500
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                wr_en_i,
    input  logic [1:0]          wr_addr_i,
    input  logic [DW-1:0]       wr_data_i,
    input  logic [NIRQ-1:0]     irq_i,
    input  logic [5:0]          wake_src_i,
    input  logic [2:0]          rst_src_i,
    output logic [1:0]          mode_o,
    output logic                ready_o,
    output logic [NSUB-1:0]     sub_en_o,
    output logic [NREG-1:0]     reg_en_o,
    output logic                reg_lp_en_o,
    output logic                clk_en_o,
    output logic                lsclk_en_o,
    output logic                i2c_run_o,
    output logic                retain_o,
    output logic                wake_vld_o,
    output logic [2:0]          wake_cause_o
);
    localparam int TW   = NSUB + NREG;
    localparam int MAXL = (HIB_LAT > SLP_LAT) ? HIB_LAT : SLP_LAT;
    localparam int CW   = $clog2(MAXL + 1);
    localparam logic [TW-1:0] ACT_DEF = '1;
    localparam logic [TW-1:0] ALT_DEF =
        {{NREG{1'b1}}, {(NSUB - NSUB/2){1'b0}}, {(NSUB/2){1'b1}}};

    typedef struct packed {
        pmode_e               mode;
        logic [TW-1:0]        tpl_act;
        logic [TW-1:0]        tpl_alt;
        logic [NIRQ-1:0]      irq_en;
        logic                 wake_vld;
        logic [CAUSE_W-1:0]   cause;
    } st_t;

    localparam st_t ST_RST = '{mode: MODE_ACT, tpl_act: ACT_DEF, tpl_alt: ALT_DEF,
                               irq_en: '1, wake_vld: 1'b0, cause: '0};

    st_t st_d, st_q;

    logic               rst_hit, wake_hit, irq_hit, req_ok;
    logic [1:0]         rst_idx;
    logic [CAUSE_W-1:0] wake_idx;
    logic               lat_busy, lat_done, lat_load, lat_clr;
    logic [CW-1:0]      lat_val;
    pmode_e             req_mode;

    pmc_src_sel #(.N(NRST), .IW(2)) u_rsel (
        .req_i  (rst_src_i),
        .mask_i (rst_mask(st_q.mode)),
        .hit_o  (rst_hit),
        .idx_o  (rst_idx)
    );

    pmc_src_sel #(.N(NWAKE), .IW(CAUSE_W)) u_wsel (
        .req_i  (wake_src_i),
        .mask_i (wake_mask(st_q.mode)),
        .hit_o  (wake_hit),
        .idx_o  (wake_idx)
    );

    pmc_latency #(.CW(CW)) u_lat (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .clr_i  (lat_clr),
        .load_i (lat_load),
        .val_i  (lat_val),
        .busy_o (lat_busy),
        .done_o (lat_done)
    );

    assign irq_hit  = (st_q.mode == MODE_ALT) && (|(irq_i & st_q.irq_en));
    assign req_mode = pmode_e'(wr_data_i[1:0]);
    assign req_ok   = wr_en_i && (wr_addr_i == A_MODE) && !is_low(st_q.mode)
                      && !lat_busy && (req_mode != st_q.mode);
    assign lat_val  = (st_q.mode == MODE_HIB) ? CW'(HIB_LAT) : CW'(SLP_LAT);

    always_comb begin
        st_d          = st_q;
        st_d.wake_vld = 1'b0;
        lat_load      = 1'b0;
        lat_clr       = 1'b0;
        if (rst_hit) begin
            st_d     = ST_RST;
            lat_clr  = 1'b1;
        end else begin
            if (lat_done) begin
                st_d.mode = MODE_ACT;
            end else if (lat_busy) begin
                st_d.mode = st_q.mode;
            end else if (wake_hit) begin
                lat_load      = 1'b1;
                st_d.wake_vld = 1'b1;
                st_d.cause    = wake_idx;
            end else if (irq_hit) begin
                st_d.mode     = MODE_ACT;
                st_d.wake_vld = 1'b1;
                st_d.cause    = CAUSE_IRQ;
            end else if (req_ok) begin
                st_d.mode = req_mode;
            end
            if (wr_en_i) begin
                case (wr_addr_i)
                    A_TACT:  st_d.tpl_act = wr_data_i[TW-1:0];
                    A_TALT:  st_d.tpl_alt = wr_data_i[TW-1:0];
                    A_IRQ:   st_d.irq_en  = wr_data_i[NIRQ-1:0];
                    default: ;
                endcase
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= ST_RST;
        else         st_q <= st_d;
    end

    pmc_out_dec #(.NSUB(NSUB), .NREG(NREG)) u_dec (
        .mode_i      (st_q.mode),
        .waking_i    (lat_busy),
        .tpl_act_i   (st_q.tpl_act),
        .tpl_alt_i   (st_q.tpl_alt),
        .sub_en_o    (sub_en_o),
        .reg_en_o    (reg_en_o),
        .reg_lp_en_o (reg_lp_en_o),
        .clk_en_o    (clk_en_o),
        .lsclk_en_o  (lsclk_en_o),
        .i2c_run_o   (i2c_run_o),
        .retain_o    (retain_o)
    );

    assign mode_o       = st_q.mode;
    assign ready_o      = !is_low(st_q.mode);
    assign wake_vld_o   = st_q.wake_vld;
    assign wake_cause_o = st_q.cause;

    logic unused_rst_idx;
    assign unused_rst_idx = ^rst_idx;
endmodule

// File: rtl/pmc_checker.sv
module pmc_checker #(
    parameter int NSUB = 8
) (
    input logic            clk_i,
    input logic            rst_ni,
    input logic [2:0]      rst_src_i,
    input logic [1:0]      mode_o,
    input logic            ready_o,
    input logic [NSUB-1:0] sub_en_o,
    input logic            retain_o,
    input logic            wake_vld_o,
    input logic [2:0]      wake_cause_o
);
    logic low;
    assign low = (mode_o == 2'd2) || (mode_o == 2'd3);

    a_r4_low_forced_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        low |-> (sub_en_o == '0) && retain_o);

    a_r7_not_ready_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
        low |-> !ready_o);

    a_r2_sleep_exit_only_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mode_o == 2'd2) |=> (mode_o == 2'd2) || (mode_o == 2'd0));

    a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wake_vld_o |=> !wake_vld_o);

    a_r8_hib_pin_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wake_vld_o && mode_o == 2'd3) |-> (wake_cause_o == 3'd1));

    a_r10_ext_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rst_src_i[0] |=> (mode_o == 2'd0) && ready_o);
endmodule

bind pwr_mode_ctrl pmc_checker #(.NSUB(NSUB)) u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .rst_src_i    (rst_src_i),
    .mode_o       (mode_o),
    .ready_o      (ready_o),
    .sub_en_o     (sub_en_o),
    .retain_o     (retain_o),
    .wake_vld_o   (wake_vld_o),
    .wake_cause_o (wake_cause_o)
);

// File: tb/sim_pwr_mode_ctrl.sv
module sim_pwr_mode_ctrl;
    localparam int SL = 5;
    localparam int HL = 9;

    logic        clk = 1'b0;
    logic        rst_ni = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [7:0]  irq = '0;
    logic [5:0]  wake = '0;
    logic [2:0]  rsrc = '0;
    logic [1:0]  mode;
    logic        ready, lp, clk_en, ls, i2c, retain, vld;
    logic [7:0]  sub;
    logic [1:0]  regen;
    logic [2:0]  cause;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pwr_mode_ctrl #(.SLP_LAT(SL), .HIB_LAT(HL)) u0 (
        .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
        .wr_data_i(wr_data), .irq_i(irq), .wake_src_i(wake), .rst_src_i(rsrc),
        .mode_o(mode), .ready_o(ready), .sub_en_o(sub), .reg_en_o(regen),
        .reg_lp_en_o(lp), .clk_en_o(clk_en), .lsclk_en_o(ls), .i2c_run_o(i2c),
        .retain_o(retain), .wake_vld_o(vld), .wake_cause_o(cause)
    );

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic check(string r, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", r, act, exp);
        end
    endtask

    task automatic wr(int a, int d);
        wr_en = 1'b1; wr_addr = 2'(a); wr_data = 16'(d);
        tick;
        wr_en = 1'b0;
    endtask

    task automatic rpulse(int b);
        rsrc = 3'(1 << b);
        tick;
        rsrc = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) tick;
        rst_ni = 1'b1;
        tick;
        // R1
        check("R1 mode", mode, 0);
        check("R1 ready", ready, 1);
        check("R1 sub_en", sub, 255);
        check("R1 reg_en", regen, 3);
        check("R1 wake_vld", vld, 0);

        // R3 template sweep in both run modes
        for (int p = 0; p < 8; p++) begin
            int pa, pb;
            pa = (p * 149 + 5) & 16'h3FF;
            pb = (p * 83 + 300) & 16'h3FF;
            wr(1, pa);
            check("R3 act sub", sub, pa & 255);
            check("R3 act reg", regen, pa >> 8);
            wr(2, pb);
            wr(0, 1);
            check("R3 alt mode", mode, 1);
            check("R3 alt sub", sub, pb & 255);
            check("R3 alt reg", regen, pb >> 8);
            wr(0, 0);
            check("R3 back", mode, 0);
        end

        // R2 requests and ignores; R4/R5 low-mode outputs
        rpulse(0);
        wr(0, 0);
        check("R2 same mode", mode, 0);
        for (int m = 1; m < 4; m++) begin
            rpulse(0);
            wr(0, m);
            check("R2 enter", mode, m);
            if (m >= 2) begin
                wr(0, 1);
                check("R2 ignore alt req", mode, m);
                wr(0, 0);
                check("R2 ignore act req", mode, m);
                check("R4 sub off", sub, 0);
                check("R4 reg off", regen, 0);
                check("R4 clk off", clk_en, 0);
                check("R4 retain", retain, 1);
                check("R4 lp reg", lp, 1);
                check("R5 lsclk", ls, (m == 2) ? 1 : 0);
                check("R5 i2c", i2c, (m == 2) ? 1 : 0);
            end else begin
                check("R5 run retain", retain, 0);
                check("R4 lp reg run", lp, 1);
                wr(0, 1);
                check("R2 same alt", mode, 1);
            end
        end

        // R6 interrupt wake from reduced run with masks
        for (int i = 0; i < 8; i++) begin
            int en;
            bit woke;
            en = (i % 2 == 1) ? 255 : (255 & ~(1 << i));
            woke = ((en >> i) & 1) == 1;
            rpulse(0);
            wr(3, en);
            wr(0, 1);
            irq = 8'(1 << i);
            tick;
            irq = '0;
            check("R6 irq mode", mode, woke ? 0 : 1);
            check("R6 irq pulse", vld, woke ? 1 : 0);
            if (woke) check("R6 irq cause", cause, 6);
            tick;
            check("R9 pulse ends", vld, 0);
        end

        // R7 sleep wake from each source, latency
        for (int s = 0; s < 6; s++) begin
            rpulse(0);
            wr(0, 2);
            wake = 6'(1 << s);
            tick;
            wake = '0;
            check("R9 sleep pulse", vld, 1);
            check("R9 sleep cause", cause, s);
            check("R7 wait ready", ready, 0);
            check("R7 wait clk", clk_en, 1);
            for (int k = 1; k < SL; k++) begin
                if (s == 0 && k == 1) wr(0, 1);
                else tick;
                check("R7 still waiting", ready, 0);
                check("R7 wait sub off", sub, 0);
            end
            tick;
            check("R7 ready", ready, 1);
            check("R7 mode run", mode, 0);
        end

        // R9 priority among simultaneous sources
        rpulse(0);
        wr(0, 2);
        wake = 6'b101100;
        tick;
        wake = '0;
        check("R9 lowest cause", cause, 2);

        // R8 deep sleep: only pin source
        for (int s = 0; s < 6; s++) begin
            rpulse(0);
            wr(0, 3);
            wake = 6'(1 << s);
            tick;
            wake = '0;
            if (s != 1) begin
                check("R8 ignored pulse", vld, 0);
                tick;
                check("R8 ignored mode", mode, 3);
                check("R8 ignored ready", ready, 0);
            end else begin
                check("R8 pin cause", cause, 1);
                for (int k = 1; k < HL; k++) begin
                    tick;
                    check("R8 waiting", ready, 0);
                end
                tick;
                check("R8 ready", ready, 1);
                check("R8 mode run", mode, 0);
            end
        end

        // R10 per-mode reset masks
        for (int m = 0; m < 4; m++) begin
            for (int b = 0; b < 3; b++) begin
                bit acc;
                acc = !(m == 3 && b != 0);
                rpulse(0);
                wr(1, 5);
                if (m != 0) wr(0, m);
                rpulse(b);
                check("R10 reset mode", mode, acc ? 0 : m);
                if (acc) begin
                    check("R10 template restored", sub, 255);
                    check("R10 ready", ready, 1);
                end
            end
        end

        // R10 reset cancels a wakeup wait
        rpulse(0);
        wr(0, 2);
        wake = 6'b000001;
        tick;
        wake = '0;
        tick;
        rpulse(1);
        check("R10 cancel mode", mode, 0);
        check("R10 cancel ready", ready, 1);
        check("R10 cancel clk", clk_en, 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule